// File: doc/BRIEF.md
# UART Interrupt Source Tracker

This block keeps the pending state of a UART's receive-side interrupt sources and turns it into one interrupt request and a prioritised status code. It tracks three line-error conditions (parity, framing and break), an Xoff detection, a special-character detection and an Xon detection. Character matching and the FIFO storage live elsewhere. The block only sees pulses telling it what happened on each clock.

Line-error interrupts can be raised at either of two points. They can be raised when the bad character is written into the receive FIFO. They can also be raised later, when that character reaches the head of the FIFO, which is the receive holding register. A separate mode input picks how the Xoff and special-character interrupts are cleared. In relaxed mode, a later receive event can clear them on its own. In strict mode, only a read of the interrupt status clears them.

A status read clears only the class that the status code reports at that moment. The remaining sources are then reported by the following reads.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset, every pending flag is 0, `irq` is 0 and `int_code` is 3'b001 (nothing pending).
- R2: With `err_imm` = 0, `err_pend` bit i is set by `head_adv` with `head_err[i]` = 1 (bit 0 parity, bit 1 framing, bit 2 break). A `fifo_wr` carrying error flags has no effect on `err_pend`.
- R3: With `err_imm` = 1, `err_pend` bit i is set by `fifo_wr` with `wr_err[i]` = 1. A `head_adv` carrying error flags has no effect on `err_pend`.
- R4: With `clr_strict` = 0, a pending Xoff is cleared by `xon_hit`, or by an `isr_rd` while the code is 3'b100.
- R5: With `clr_strict` = 0, a pending special-character flag is cleared by `char_rx`, or by an `isr_rd` while the code is 3'b100.
- R6: With `clr_strict` = 1, neither `xon_hit` nor `char_rx` clears the Xoff or special-character flags. Only an `isr_rd` while the code is 3'b100 clears them.
- R7: The Xon flag is cleared only by an `isr_rd` while the code is 3'b010. `char_rx` and the mode inputs never clear it.
- R8: `irq` is 1 exactly when some pending source is enabled. `ie_err` gates `err_pend`, and `ie_flow` gates the Xoff, special-character and Xon flags. Masking hides a source but does not clear its flag.
- R9: `int_code` reports the highest-priority enabled class. The codes are 3'b110 for a line error, 3'b100 for Xoff or special character, 3'b010 for Xon and 3'b001 for none. An `isr_rd` clears only the class reported in that cycle.
- R10: When a set event and a clear event hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_imm | input | 1 | 1: raise errors at FIFO write; 0: raise errors at holding register |
| clr_strict | input | 1 | 1: Xoff/special flags clear only on status read |
| ie_err | input | 1 | Enable for line-error interrupts |
| ie_flow | input | 1 | Enable for Xoff, special-character and Xon interrupts |
| fifo_wr | input | 1 | A character is written into the receive FIFO |
| wr_err | input | ERR_W | Error flags of the character being written |
| head_adv | input | 1 | A character arrives at the receive holding register |
| head_err | input | ERR_W | Error flags of the character at the holding register |
| xoff_hit | input | 1 | Xoff character detected |
| xon_hit | input | 1 | Xon character detected |
| spec_hit | input | 1 | Special character detected |
| char_rx | input | 1 | Any character received |
| isr_rd | input | 1 | Interrupt status read strobe |
| err_pend | output | ERR_W | Pending line-error flags |
| xoff_pend | output | 1 | Pending Xoff flag |
| spec_pend | output | 1 | Pending special-character flag |
| xon_pend | output | 1 | Pending Xon flag |
| irq | output | 1 | Interrupt request |
| int_code | output | 3 | Prioritised status code |

## Verification
The sensitive overlap is a status read that lands in the same cycle as a receive event for the class being cleared. Examples are an `isr_rd` together with a fresh `head_err`, and a `char_rx` together with a `spec_hit`. The bench pulses both inputs on one clock and then reads the flags on the next cycle. The flags must hold the new event, and any older bits that were cleared must be gone. A second overlap places `xon_hit` and `xoff_hit` on one edge in relaxed mode. The Xoff flag must stay set while Xon rises.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  typedef enum logic [2:0] {
    CODE_NONE = 3'b001,
    CODE_XON  = 3'b010,
    CODE_FLOW = 3'b100,
    CODE_ERR  = 3'b110
  } irq_code_e;

  // next value of a sticky flag: set dominates clear
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/uirq_err_track.sv
module uirq_err_track #(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_imm,
  input  logic             fifo_wr,
  input  logic [ERR_W-1:0] wr_err,
  input  logic             head_adv,
  input  logic [ERR_W-1:0] head_err,
  input  logic             clr_err,
  output logic [ERR_W-1:0] err_set,
  output logic [ERR_W-1:0] err_pend
);
  import uirq_pkg::*;

  logic [ERR_W-1:0] wr_sel;
  logic [ERR_W-1:0] hd_sel;

  assign wr_sel  = fifo_wr  ? wr_err   : '0;
  assign hd_sel  = head_adv ? head_err : '0;
  assign err_set = err_imm  ? wr_sel   : hd_sel;

  for (genvar i = 0; i < ERR_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) err_pend[i] <= 1'b0;
      else        err_pend[i] <= sticky_next(err_pend[i], err_set[i], clr_err);
    end
  end
endmodule

// File: rtl/uirq_flow_track.sv
module uirq_flow_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_strict,
  input  logic xoff_hit,
  input  logic xon_hit,
  input  logic spec_hit,
  input  logic char_rx,
  input  logic clr_flow,
  input  logic clr_xon,
  output logic xoff_auto_clr,
  output logic spec_auto_clr,
  output logic xoff_pend,
  output logic spec_pend,
  output logic xon_pend
);
  import uirq_pkg::*;

  assign xoff_auto_clr = ~clr_strict & xon_hit;
  assign spec_auto_clr = ~clr_strict & char_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xoff_pend <= 1'b0;
      spec_pend <= 1'b0;
      xon_pend  <= 1'b0;
    end else begin
      xoff_pend <= sticky_next(xoff_pend, xoff_hit, clr_flow | xoff_auto_clr);
      spec_pend <= sticky_next(spec_pend, spec_hit, clr_flow | spec_auto_clr);
      xon_pend  <= sticky_next(xon_pend,  xon_hit,  clr_xon);
    end
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio #(
  parameter int ERR_W = 3
) (
  input  logic             ie_err,
  input  logic             ie_flow,
  input  logic             isr_rd,
  input  logic [ERR_W-1:0] err_pend,
  input  logic             xoff_pend,
  input  logic             spec_pend,
  input  logic             xon_pend,
  output logic             irq,
  output logic [2:0]       int_code,
  output logic             clr_err,
  output logic             clr_flow,
  output logic             clr_xon
);
  import uirq_pkg::*;

  logic      act_err;
  logic      act_flow;
  logic      act_xon;
  irq_code_e code;

  assign act_err  = ie_err  & (|err_pend);
  assign act_flow = ie_flow & (xoff_pend | spec_pend);
  assign act_xon  = ie_flow & xon_pend;

  always_comb begin
    if (act_err)       code = CODE_ERR;
    else if (act_flow) code = CODE_FLOW;
    else if (act_xon)  code = CODE_XON;
    else               code = CODE_NONE;
  end

  assign int_code = code;
  assign irq      = act_err | act_flow | act_xon;
  assign clr_err  = isr_rd & (code == CODE_ERR);
  assign clr_flow = isr_rd & (code == CODE_FLOW);
  assign clr_xon  = isr_rd & (code == CODE_XON);
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl #(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_imm,
  input  logic             clr_strict,
  input  logic             ie_err,
  input  logic             ie_flow,
  input  logic             fifo_wr,
  input  logic [ERR_W-1:0] wr_err,
  input  logic             head_adv,
  input  logic [ERR_W-1:0] head_err,
  input  logic             xoff_hit,
  input  logic             xon_hit,
  input  logic             spec_hit,
  input  logic             char_rx,
  input  logic             isr_rd,
  output logic [ERR_W-1:0] err_pend,
  output logic             xoff_pend,
  output logic             spec_pend,
  output logic             xon_pend,
  output logic             irq,
  output logic [2:0]       int_code
);
  // named internal events, visible to the bound checker
  logic             clr_err;
  logic             clr_flow;
  logic             clr_xon;
  logic [ERR_W-1:0] err_set;
  logic             xoff_auto_clr;
  logic             spec_auto_clr;

  uirq_err_track #(.ERR_W(ERR_W)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_imm  (err_imm),
    .fifo_wr  (fifo_wr),
    .wr_err   (wr_err),
    .head_adv (head_adv),
    .head_err (head_err),
    .clr_err  (clr_err),
    .err_set  (err_set),
    .err_pend (err_pend)
  );

  uirq_flow_track u_flow (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_strict    (clr_strict),
    .xoff_hit      (xoff_hit),
    .xon_hit       (xon_hit),
    .spec_hit      (spec_hit),
    .char_rx       (char_rx),
    .clr_flow      (clr_flow),
    .clr_xon       (clr_xon),
    .xoff_auto_clr (xoff_auto_clr),
    .spec_auto_clr (spec_auto_clr),
    .xoff_pend     (xoff_pend),
    .spec_pend     (spec_pend),
    .xon_pend      (xon_pend)
  );

  uirq_prio #(.ERR_W(ERR_W)) u_prio (
    .ie_err    (ie_err),
    .ie_flow   (ie_flow),
    .isr_rd    (isr_rd),
    .err_pend  (err_pend),
    .xoff_pend (xoff_pend),
    .spec_pend (spec_pend),
    .xon_pend  (xon_pend),
    .irq       (irq),
    .int_code  (int_code),
    .clr_err   (clr_err),
    .clr_flow  (clr_flow),
    .clr_xon   (clr_xon)
  );
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_imm,
  input logic             clr_strict,
  input logic             ie_err,
  input logic             ie_flow,
  input logic             fifo_wr,
  input logic             head_adv,
  input logic             xoff_hit,
  input logic             spec_hit,
  input logic             xon_hit,
  input logic             char_rx,
  input logic             isr_rd,
  input logic [ERR_W-1:0] err_pend,
  input logic             xoff_pend,
  input logic             spec_pend,
  input logic             xon_pend,
  input logic             irq,
  input logic [2:0]       int_code,
  input logic             clr_flow,
  input logic             clr_xon
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (err_pend == '0 && !xoff_pend && !spec_pend && !xon_pend)); // R1
  AST_ERR_DELAYED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(err_imm) && (err_pend & ~$past(err_pend)) != '0) |-> $past(head_adv)); // R2
  AST_ERR_IMM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_imm) && (err_pend & ~$past(err_pend)) != '0) |-> $past(fifo_wr)); // R3
  AST_SPEC_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_strict && spec_pend && char_rx && !spec_hit) |=> !spec_pend); // R5
  AST_STRICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strict && xoff_pend && !clr_flow) |=> xoff_pend); // R6
  AST_XON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_pend && !clr_xon) |=> xon_pend); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ie_err && err_pend != '0) || (ie_flow && (xoff_pend || spec_pend || xon_pend)))); // R8
  AST_CODE_ONEHOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd |-> $onehot0({clr_flow, clr_xon, int_code == 3'b110})); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_hit || xoff_hit) |=> (spec_pend || xoff_pend)); // R10
endmodule

bind uirq_ctrl uirq_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .err_imm    (err_imm),
  .clr_strict (clr_strict),
  .ie_err     (ie_err),
  .ie_flow    (ie_flow),
  .fifo_wr    (fifo_wr),
  .head_adv   (head_adv),
  .xoff_hit   (xoff_hit),
  .spec_hit   (spec_hit),
  .xon_hit    (xon_hit),
  .char_rx    (char_rx),
  .isr_rd     (isr_rd),
  .err_pend   (err_pend),
  .xoff_pend  (xoff_pend),
  .spec_pend  (spec_pend),
  .xon_pend   (xon_pend),
  .irq        (irq),
  .int_code   (int_code),
  .clr_flow   (clr_flow),
  .clr_xon    (clr_xon)
);

// File: tb/uirq_ctrl_test.sv
module uirq_ctrl_test;
  localparam int EW = 3;
  localparam logic [2:0] C_NONE = 3'b001, C_XON = 3'b010,
                         C_FLOW = 3'b100, C_ERR = 3'b110;

  logic clk = 1'b0;
  logic rst_n, err_imm, clr_strict, ie_err, ie_flow;
  logic fifo_wr, head_adv, xoff_hit, xon_hit, spec_hit, char_rx, isr_rd;
  logic [EW-1:0] wr_err, head_err, err_pend;
  logic xoff_pend, spec_pend, xon_pend, irq;
  logic [2:0] int_code;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uirq_ctrl #(.ERR_W(EW)) uut (.*);

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    fifo_wr = 0; head_adv = 0; xoff_hit = 0; xon_hit = 0;
    spec_hit = 0; char_rx = 0; isr_rd = 0; wr_err = '0; head_err = '0;
  endtask

  // apply the currently driven pulses for one edge, then release them
  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0; err_imm = 0; clr_strict = 0; ie_err = 1; ie_flow = 1;
    idle();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 err_pend", err_pend, 0);
    chk("R1 flow flags", {xoff_pend, spec_pend, xon_pend}, 0);
    chk("R1 irq", irq, 0);
    chk("R1 code", int_code, C_NONE);
  endtask

  task automatic t_delayed();
    do_reset();
    fifo_wr = 1; wr_err = 3'b001; tick();
    chk("R2 fifo_wr ignored", err_pend, 0);
    head_adv = 1; head_err = 3'b101; tick();
    chk("R2 head sets", err_pend, 3'b101);
    chk("R9 code err", int_code, C_ERR);
    isr_rd = 1; tick();
    chk("R9 read clears err", err_pend, 0);
  endtask

  task automatic t_immediate();
    do_reset(); err_imm = 1;
    head_adv = 1; head_err = 3'b010; tick();
    chk("R3 head ignored", err_pend, 0);
    fifo_wr = 1; wr_err = 3'b010; tick();
    chk("R3 fifo_wr sets", err_pend, 3'b010);
    chk("R8 irq err", irq, 1);
  endtask

  task automatic t_xoff_relaxed();
    do_reset();
    xoff_hit = 1; tick();
    chk("R4 xoff set", xoff_pend, 1);
    chk("R9 code flow", int_code, C_FLOW);
    xon_hit = 1; tick();
    chk("R4 xon clears xoff", xoff_pend, 0);
    chk("R7 xon set", xon_pend, 1);
    chk("R9 code xon", int_code, C_XON);
    char_rx = 1; tick();
    chk("R7 char_rx keeps xon", xon_pend, 1);
    isr_rd = 1; tick();
    chk("R7 read clears xon", xon_pend, 0);
    xoff_hit = 1; tick();
    isr_rd = 1; tick();
    chk("R4 read clears xoff", xoff_pend, 0);
  endtask

  task automatic t_spec_relaxed();
    do_reset();
    spec_hit = 1; tick();
    chk("R5 spec set", spec_pend, 1);
    char_rx = 1; tick();
    chk("R5 char_rx clears spec", spec_pend, 0);
    spec_hit = 1; char_rx = 1; tick();
    chk("R10 spec set beats char_rx", spec_pend, 1);
    isr_rd = 1; tick();
    chk("R5 read clears spec", spec_pend, 0);
  endtask

  task automatic t_strict();
    do_reset(); clr_strict = 1;
    xoff_hit = 1; spec_hit = 1; tick();
    xon_hit = 1; tick();
    char_rx = 1; tick();
    chk("R6 xoff held", xoff_pend, 1);
    chk("R6 spec held", spec_pend, 1);
    chk("R9 flow over xon", int_code, C_FLOW);
    isr_rd = 1; tick();
    chk("R6 read clears flow", {xoff_pend, spec_pend}, 0);
    chk("R9 xon untouched", xon_pend, 1);
    isr_rd = 1; tick();
    chk("R7 second read clears xon", xon_pend, 0);
  endtask

  task automatic t_prio_mask();
    do_reset();
    ie_err = 0;
    head_adv = 1; head_err = 3'b100; xon_hit = 1; tick();
    chk("R8 masked err code", int_code, C_XON);
    ie_flow = 0; #1;
    chk("R8 all masked irq", irq, 0);
    chk("R8 flags kept", {err_pend, xon_pend}, 4'b1001);
    ie_err = 1; ie_flow = 1; #1;
    chk("R9 err over xon", int_code, C_ERR);
    isr_rd = 1; tick();
    chk("R9 only err cleared", {err_pend, xon_pend}, 4'b0001);
  endtask

  task automatic t_collide();
    do_reset();
    head_adv = 1; head_err = 3'b001; tick();
    isr_rd = 1; head_adv = 1; head_err = 3'b100; tick();
    chk("R10 err set beats read", err_pend, 3'b100);
    xoff_hit = 1; tick();
    xoff_hit = 1; xon_hit = 1; tick();
    chk("R10 xoff set beats xon", xoff_pend, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_delayed();
    t_immediate();
    t_xoff_relaxed();
    t_spec_relaxed();
    t_strict();
    t_prio_mask();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule